// File: doc/BRIEF.md
# Floppy formatter host register file

This block is the set of byte-wide registers that a processor sees on a floppy disk formatter. There are five: a Data byte, the current head Track, the target Sector, a Command byte and a Status byte. The processor reaches them over a small parallel bus made of a chip select, a read/write line and a two-bit register address. Each register has its own direction: Command can only be written, Status can only be read, and the other three can be both written and read.

The controller core sits behind the block. It receives the accepted command through an output byte and a one-cycle strobe. It loads Status and moves disk bytes into Data through side ports. It sends head step pulses, and the Track register follows them. It reports the end of a command with a done pulse. While a command runs, the block is busy. During that time it drops processor writes to Command, Track and Sector, with one exception: a force-interrupt command is always taken, and it ends the busy state. Data stays writable while busy, so byte transfers can go on. During a seek, Data holds the target track, and the core reads it from `data_o`. Two equality flags compare Track and Sector with the numbers decoded from a sector ID field.

Top module: `fdc_host_regs`

## Requirements
- R1: After reset, all five registers are 0x00, `busy_o` and `cmd_valid_o` are low, and each register reads back 0x00.
- R2: The address is decoded as 01 = Track, 10 = Sector, 11 = Data, and 00 = Command on a write or Status on a read. An idle write is visible on `rdata_o` from the next cycle. `rdata_o` is 0x00 when `cs_i` is low or when `we_i` is high.
- R3: Command cannot be read: a read at address 00 returns Status. An accepted command appears on `cmd_o`, and `cmd_valid_o` is high for exactly the one cycle that follows the write edge.
- R4: Status is loaded only from `status_i` when `status_load_i` is high. A bus write at address 00 never changes Status.
- R5: A command whose upper nibble is not 0xD, written while idle, sets `busy_o` from the next cycle. `done_i` clears `busy_o` on the next edge.
- R6: A command write whose upper nibble is not 0xD, made while busy, is dropped: there is no strobe and `cmd_o` keeps its value.
- R7: A command whose upper nibble is 0xD (force interrupt) is accepted whether or not the block is busy. It strobes `cmd_valid_o` and leaves `busy_o` low from the next cycle.
- R8: Bus writes to Track and Sector made while busy leave both registers unchanged.
- R9: A `step_in_i` pulse adds one to Track and a `step_out_i` pulse subtracts one. Both together leave Track unchanged. An idle bus write to Track in the same cycle wins over a step.
- R10: Track holds at 0x00 on a step-out and at 0xFF on a step-in.
- R11: Data accepts bus writes while busy. `disk_load_i` loads `disk_data_i` and wins over a bus write in the same cycle. `data_o` always shows Data.
- R12: `track_match_o` is high exactly when Track equals `id_track_i`, and `sector_match_o` is high exactly when Sector equals `id_sector_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus chip select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Bus write byte |
| rdata_o | output | 8 | Bus read byte |
| status_load_i | input | 1 | Core loads Status |
| status_i | input | 8 | New Status byte |
| disk_load_i | input | 1 | Core loads Data from the disk side |
| disk_data_i | input | 8 | Assembled disk byte |
| step_in_i | input | 1 | Head stepped inward |
| step_out_i | input | 1 | Head stepped toward track zero |
| done_i | input | 1 | Command finished |
| id_track_i | input | 8 | Track number read from an ID field |
| id_sector_i | input | 8 | Sector number read from an ID field |
| cmd_o | output | 8 | Current command byte |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| busy_o | output | 1 | A command is in progress |
| data_o | output | 8 | Data register (seek target) |
| track_o | output | 8 | Track register |
| sector_o | output | 8 | Sector register |
| track_match_o | output | 1 | Track equals the ID track |
| sector_match_o | output | 1 | Sector equals the ID sector |

## Verification
The assertions assume that every input is synchronous to `clk_i` and stable at the sampling edge. They also assume that a step pulse lasts one cycle, and that `done_i` comes only while a command is running. The stimulus meets these assumptions: it changes inputs on falling edges, gives each step and each done a single cycle, and never raises `done_i` while idle. Same-cycle collisions are provoked on purpose (both step directions, an idle Track write against a step, a disk load against a bus write) to pin down the stated priorities.

// File: rtl/fdc_reg_pkg.sv
package fdc_reg_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CMD_STAT = 2'b00,
    SEL_TRACK    = 2'b01,
    SEL_SECTOR   = 2'b10,
    SEL_DATA     = 2'b11
  } reg_sel_e;

  typedef struct packed {
    logic wr_cmd;
    logic wr_track;
    logic wr_sector;
    logic wr_data;
    logic rd_en;
  } bus_dec_t;
endpackage

// File: rtl/fdc_addr_decode.sv
module fdc_addr_decode
  import fdc_reg_pkg::*;
(
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bus_dec_t          dec_o
);
  reg_sel_e sel;
  logic     wr;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = cs_i & we_i;

  always_comb begin
    dec_o = '0;
    dec_o.rd_en = cs_i & ~we_i;
    unique case (sel)
      SEL_CMD_STAT: dec_o.wr_cmd    = wr;
      SEL_TRACK:    dec_o.wr_track  = wr;
      SEL_SECTOR:   dec_o.wr_sector = wr;
      SEL_DATA:     dec_o.wr_data   = wr;
      default:      dec_o = '0;
    endcase
  end

  always_comb begin
    assert ($countones({dec_o.wr_cmd, dec_o.wr_track, dec_o.wr_sector, dec_o.wr_data}) <= 1)
      else $error("assert_one_write_R2");
  end
endmodule

// File: rtl/fdc_byte_reg.sv
// Byte register with two load ports; port A has priority.
module fdc_byte_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_a_i,
  input  logic [WIDTH-1:0] data_a_i,
  input  logic             load_b_i,
  input  logic [WIDTH-1:0] data_b_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (load_a_i) q_o <= data_a_i;
    else if (load_b_i) q_o <= data_b_i;
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_a_i && !load_b_i |=> $stable(q_o))
    else $error("assert_hold_when_idle_R4");
endmodule

// File: rtl/fdc_cmd_ctrl.sv
module fdc_cmd_ctrl
  import fdc_reg_pkg::*;
#(
  parameter int unsigned     WIDTH   = REG_W,
  parameter logic [OP_W-1:0] ABORT_OP = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_cmd_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             done_i,
  output logic [WIDTH-1:0] cmd_o,
  output logic             cmd_valid_o,
  output logic             busy_o
);
  localparam int unsigned OP_LSB = WIDTH - OP_W;

  logic is_abort, accept;

  assign is_abort = (wdata_i[WIDTH-1:OP_LSB] == ABORT_OP);
  assign accept   = wr_cmd_i & (~busy_o | is_abort);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= '0;
      cmd_valid_o <= 1'b0;
      busy_o      <= 1'b0;
    end else begin
      cmd_valid_o <= accept;
      if (accept) begin
        cmd_o  <= wdata_i;
        busy_o <= ~is_abort;
      end else if (done_i) begin
        busy_o <= 1'b0;
      end
    end
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_cmd_i && (wdata_i[WIDTH-1:OP_LSB] != ABORT_OP) |=> !cmd_valid_o && $stable(cmd_o))
    else $error("assert_busy_cmd_drop_R6");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i && (wdata_i[WIDTH-1:OP_LSB] == ABORT_OP) |=> cmd_valid_o && !busy_o)
    else $error("assert_abort_taken_R7");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && done_i && !wr_cmd_i |=> !busy_o)
    else $error("assert_done_clears_R5");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && wr_cmd_i && (wdata_i[WIDTH-1:OP_LSB] != ABORT_OP) |=> busy_o && cmd_valid_o)
    else $error("assert_cmd_sets_busy_R5");
endmodule

// File: rtl/fdc_track_reg.sv
module fdc_track_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_in_i,
  input  logic             step_out_i,
  output logic [WIDTH-1:0] track_o
);
  localparam logic [WIDTH-1:0] TRK_MAX = '1;
  localparam logic [WIDTH-1:0] TRK_MIN = '0;

  logic do_in, do_out;
  assign do_in  = step_in_i & ~step_out_i;
  assign do_out = step_out_i & ~step_in_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          track_o <= '0;
    else if (load_i)                      track_o <= load_val_i;
    else if (do_in  && track_o != TRK_MAX) track_o <= track_o + 1'b1;
    else if (do_out && track_o != TRK_MIN) track_o <= track_o - 1'b1;
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && step_in_i && !step_out_i && track_o != TRK_MAX |=> track_o == $past(track_o) + 1'b1)
    else $error("assert_step_in_R9");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && step_out_i && !step_in_i && track_o != TRK_MIN |=> track_o == $past(track_o) - 1'b1)
    else $error("assert_step_out_R9");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && step_in_i && track_o == TRK_MAX |=> track_o == TRK_MAX)
    else $error("assert_sat_high_R10");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && step_out_i && track_o == TRK_MIN |=> track_o == TRK_MIN)
    else $error("assert_sat_low_R10");
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             status_load_i,
  input  logic [REG_W-1:0] status_i,
  input  logic             disk_load_i,
  input  logic [REG_W-1:0] disk_data_i,
  input  logic             step_in_i,
  input  logic             step_out_i,
  input  logic             done_i,
  input  logic [REG_W-1:0] id_track_i,
  input  logic [REG_W-1:0] id_sector_i,
  output logic [REG_W-1:0] cmd_o,
  output logic             cmd_valid_o,
  output logic             busy_o,
  output logic [REG_W-1:0] data_o,
  output logic [REG_W-1:0] track_o,
  output logic [REG_W-1:0] sector_o,
  output logic             track_match_o,
  output logic             sector_match_o
);
  bus_dec_t         dec;
  logic [REG_W-1:0] status_q;
  logic             trk_load, sec_load;

  fdc_addr_decode u_dec (
    .cs_i  (cs_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .dec_o (dec)
  );

  fdc_cmd_ctrl #(.WIDTH(REG_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_cmd_i   (dec.wr_cmd),
    .wdata_i    (wdata_i),
    .done_i     (done_i),
    .cmd_o      (cmd_o),
    .cmd_valid_o(cmd_valid_o),
    .busy_o     (busy_o)
  );

  assign trk_load = dec.wr_track  & ~busy_o;
  assign sec_load = dec.wr_sector & ~busy_o;

  fdc_track_reg #(.WIDTH(REG_W)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (trk_load),
    .load_val_i(wdata_i),
    .step_in_i (step_in_i),
    .step_out_i(step_out_i),
    .track_o   (track_o)
  );

  fdc_byte_reg #(.WIDTH(REG_W)) u_sec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_a_i(sec_load),
    .data_a_i(wdata_i),
    .load_b_i(1'b0),
    .data_b_i('0),
    .q_o     (sector_o)
  );

  fdc_byte_reg #(.WIDTH(REG_W)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_a_i(disk_load_i),
    .data_a_i(disk_data_i),
    .load_b_i(dec.wr_data),
    .data_b_i(wdata_i),
    .q_o     (data_o)
  );

  fdc_byte_reg #(.WIDTH(REG_W)) u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_a_i(status_load_i),
    .data_a_i(status_i),
    .load_b_i(1'b0),
    .data_b_i('0),
    .q_o     (status_q)
  );

  always_comb begin
    rdata_o = '0;
    if (dec.rd_en) begin
      unique case (reg_sel_e'(addr_i))
        SEL_CMD_STAT: rdata_o = status_q;
        SEL_TRACK:    rdata_o = track_o;
        SEL_SECTOR:   rdata_o = sector_o;
        SEL_DATA:     rdata_o = data_o;
        default:      rdata_o = '0;
      endcase
    end
  end

  assign track_match_o  = (track_o  == id_track_i);
  assign sector_match_o = (sector_o == id_sector_i);

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && we_i && addr_i == SEL_CMD_STAT && !status_load_i |=> $stable(status_q))
    else $error("assert_status_ro_R4");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cs_i && we_i && addr_i == SEL_SECTOR |=> $stable(sector_o))
    else $error("assert_sector_gate_R8");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cs_i && we_i && addr_i == SEL_TRACK && !step_in_i && !step_out_i |=> $stable(track_o))
    else $error("assert_track_gate_R8");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    disk_load_i |=> data_o == $past(disk_data_i))
    else $error("assert_disk_wins_R11");
endmodule

// File: tb/tb_fdc_host_regs.sv
module tb_fdc_host_regs;
  logic       clk_i = 0, rst_ni = 0;
  logic       cs_i = 0, we_i = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0, status_i = 0, disk_data_i = 0, id_track_i = 0, id_sector_i = 0;
  logic       status_load_i = 0, disk_load_i = 0, step_in_i = 0, step_out_i = 0, done_i = 0;
  logic [7:0] rdata_o, cmd_o, data_o, track_o, sector_o;
  logic       cmd_valid_o, busy_o, track_match_o, sector_match_o;

  int total = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  fdc_host_regs dut (.*);

  // {we, addr, wdata, expected read}
  localparam logic [18:0] VEC [10] = '{
    {1'b1, 2'b01, 8'h22, 8'h00}, {1'b0, 2'b01, 8'h00, 8'h22},
    {1'b1, 2'b10, 8'h05, 8'h00}, {1'b0, 2'b10, 8'h00, 8'h05},
    {1'b1, 2'b11, 8'hA5, 8'h00}, {1'b0, 2'b11, 8'h00, 8'hA5},
    {1'b0, 2'b00, 8'h00, 8'h00}, {1'b1, 2'b01, 8'h00, 8'h00},
    {1'b0, 2'b01, 8'h00, 8'h00}, {1'b0, 2'b10, 8'h00, 8'h05}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    cs_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    cs_i = 0;
  endtask

  task automatic pulse_step(input logic in_p, input logic out_p);
    @(negedge clk_i);
    step_in_i = in_p; step_out_i = out_p;
    @(negedge clk_i);
    step_in_i = 0; step_out_i = 0;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    #20 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      bus_rd(2'(i), r); check("R1 reset read", r, 8'h00);
    end
    check("R1 busy", {7'b0, busy_o}, 8'h00);
    check("R1 strobe", {7'b0, cmd_valid_o}, 8'h00);

    // R2 vector walk
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][18]) bus_wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][17:16], r); check("R2 readback", r, VEC[i][7:0]);
      end
    end
    cs_i = 0; addr_i = 2'b11; #1 check("R2 no cs", rdata_o, 8'h00);
    cs_i = 1; we_i = 1; #1 check("R2 write cycle", rdata_o, 8'h00);
    cs_i = 0; we_i = 0;

    // R4 status load
    @(negedge clk_i); status_i = 8'h81; status_load_i = 1;
    @(negedge clk_i); status_load_i = 0;
    bus_rd(2'b00, r); check("R4 status load", r, 8'h81);

    // R3/R5 command accept
    bus_wr(2'b00, 8'h1A);
    check("R3 strobe", {7'b0, cmd_valid_o}, 8'h01);
    check("R3 cmd", cmd_o, 8'h1A);
    check("R5 busy set", {7'b0, busy_o}, 8'h01);
    bus_rd(2'b00, r); check("R3 R4 read status not cmd", r, 8'h81);
    @(negedge clk_i);
    check("R3 strobe one cycle", {7'b0, cmd_valid_o}, 8'h00);

    // R6 busy drop
    bus_wr(2'b00, 8'h20);
    check("R6 no strobe", {7'b0, cmd_valid_o}, 8'h00);
    check("R6 cmd kept", cmd_o, 8'h1A);
    // R8
    bus_wr(2'b01, 8'h33);
    check("R8 track", track_o, 8'h00);
    bus_wr(2'b10, 8'h44);
    check("R8 sector", sector_o, 8'h05);
    // R11 data while busy
    bus_wr(2'b11, 8'h77);
    check("R11 data busy", data_o, 8'h77);

    // R9/R10 stepping
    pulse_step(0, 1); check("R10 sat low", track_o, 8'h00);
    repeat (3) pulse_step(1, 0);
    check("R9 step in", track_o, 8'h03);
    pulse_step(0, 1); check("R9 step out", track_o, 8'h02);
    pulse_step(1, 1); check("R9 both", track_o, 8'h02);

    // R5 done
    @(negedge clk_i); done_i = 1;
    @(negedge clk_i); done_i = 0;
    check("R5 done clears", {7'b0, busy_o}, 8'h00);

    bus_wr(2'b01, 8'hFE);
    pulse_step(1, 0); check("R10 reach max", track_o, 8'hFF);
    pulse_step(1, 0); check("R10 sat high", track_o, 8'hFF);
    @(negedge clk_i);
    cs_i = 1; we_i = 1; addr_i = 2'b01; wdata_i = 8'h10; step_in_i = 1;
    @(negedge clk_i);
    cs_i = 0; we_i = 0; step_in_i = 0;
    check("R9 write over step", track_o, 8'h10);

    // R7 force interrupt
    bus_wr(2'b00, 8'hD0);
    check("R7 idle strobe", {7'b0, cmd_valid_o}, 8'h01);
    check("R7 idle not busy", {7'b0, busy_o}, 8'h00);
    bus_wr(2'b00, 8'h03);
    check("R5 busy again", {7'b0, busy_o}, 8'h01);
    bus_wr(2'b00, 8'hD8);
    check("R7 busy cmd", cmd_o, 8'hD8);
    check("R7 busy strobe", {7'b0, cmd_valid_o}, 8'h01);
    check("R7 busy cleared", {7'b0, busy_o}, 8'h00);

    // R11 disk load priority
    @(negedge clk_i);
    cs_i = 1; we_i = 1; addr_i = 2'b11; wdata_i = 8'h99;
    disk_load_i = 1; disk_data_i = 8'h5C;
    @(negedge clk_i);
    cs_i = 0; we_i = 0; disk_load_i = 0;
    check("R11 disk wins", data_o, 8'h5C);
    bus_rd(2'b11, r); check("R11 read data", r, 8'h5C);

    // R12 compare
    id_track_i = 8'h10; id_sector_i = 8'h05;
    #1 check("R12 track match", {7'b0, track_match_o}, 8'h01);
    check("R12 sector match", {7'b0, sector_match_o}, 8'h01);
    id_track_i = 8'h11; id_sector_i = 8'h06;
    #1 check("R12 track miss", {7'b0, track_match_o}, 8'h00);
    check("R12 sector miss", {7'b0, sector_match_o}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule